// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block samples a one-bit serial stream on each rising clock edge and raises a flag whenever the last four bits received were 1, 1, 0, 1 (oldest first). Matches may overlap. The final 1 of one match can also be the first 1 of the next, so the stream 1101101 holds two matches.

Two recognisers run side by side on the same stream. The first has four states and gives a flag in the same cycle as the completing bit. That flag is formed combinationally from its present state and the live input. A parameter chooses its state coding: a two-bit reflected binary code or a four-bit one-hot code. The second recogniser has five states and drives its flag straight from a register. Its flag therefore appears one clock later and does not depend on the live input. A synchronous, active-high reset returns both machines to their start state.

Top module: `pd_pattern_watch`

## Requirements
- R1: `rst` is synchronous and active high, and it takes priority over `din`. While `rst` is 1, `hit_now` is 0. After any clock edge that samples `rst` at 1, both machines are in their start state, so bits received before reset never complete a match.
- R2: `hit_now` is 1 during exactly those cycles in which `din` is 1 and the three bits sampled at the three previous edges were 1, 1, 0 (oldest first). It follows `din` within the same cycle.
- R3: Overlapping matches are each flagged. For the stream 1101101, `hit_now` is 1 on the 4th and 7th bits.
- R4: A run of two or more 1s followed by 0, 1 gives a single match on the last bit. For 1111101, `hit_now` is 1 only on the 7th bit.
- R5: `hit_late` is 1 in the cycle after each cycle in which `hit_now` is 1, and 0 otherwise. It is driven only from a flip-flop.
- R6: After a match, the registered machine treats further 1s as the start of a new match. For 11011101, `hit_late` is high in the cycles after the 4th and 8th bits.
- R7: A 0 received after 110 abandons the partial match. For 11001, neither flag is raised.
- R8: In one-hot coding, a state register holding no set bit or several set bits returns to the start state (bit 0 alone set) on the next clock edge.
- R9: Both settings of `MEALY_ENC` give identical flags. In `ENC_GRAY` mode the four states are coded 00, 01, 11, 10 in the order start, seen 1, seen 11, seen 110. In that mode, state bit 0 after each edge equals the `din` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit is taken per edge |
| rst | input | 1 | Synchronous active-high reset to the start state |
| din | input | 1 | Serial data bit |
| hit_now | output | 1 | Match flag for the current bit (combinational from state and `din`) |
| hit_late | output | 1 | Registered match flag, one clock after `hit_now` |

## Verification
The assertions assume that `din` is stable around each rising edge, so each edge sees a single defined bit. The bench changes `din` only on falling edges and samples results mid-phase. The lag and recovery properties also assume that the one-hot state registers change only through their own next-state logic. The exception is the single recovery test: there the bench forces an all-zero state for less than one clock, away from the active edge, and then releases it.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic {ENC_GRAY = 1'b0, ENC_ONEHOT = 1'b1} mealy_enc_e;

  localparam int MEALY_STATES = 4;
  localparam int MOORE_STATES = 5;
  localparam int GRAY_W       = $clog2(MEALY_STATES);

  // one-hot bit positions (start state sits in bit 0)
  localparam int IX_A = 0;
  localparam int IX_B = 1;
  localparam int IX_C = 2;
  localparam int IX_D = 3;
  localparam int IX_E = 4;

  // reflected binary codes for the four-state machine
  localparam logic [GRAY_W-1:0] G_A = 2'b00;
  localparam logic [GRAY_W-1:0] G_B = 2'b01;
  localparam logic [GRAY_W-1:0] G_C = 2'b11;
  localparam logic [GRAY_W-1:0] G_D = 2'b10;
endpackage

// File: rtl/pd_mealy_gray.sv
module pd_mealy_gray
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  logic [GRAY_W-1:0] st_q, st_d;

  always_comb begin
    case (st_q)
      G_A:     st_d = din ? G_B : G_A;
      G_B:     st_d = din ? G_C : G_A;
      G_C:     st_d = din ? G_C : G_D;
      G_D:     st_d = din ? G_B : G_A;
      default: st_d = G_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= G_A;
    else     st_q <= st_d;
  end

  assign hit = ~rst & din & (st_q == G_D);

  // R9: low code bit tracks the bit taken at the previous edge
  a_r9_gray_low_bit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> st_q[0] == $past(din));
endmodule

// File: rtl/pd_mealy_onehot.sv
module pd_mealy_onehot
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  localparam logic [MEALY_STATES-1:0] START = MEALY_STATES'(1);

  logic [MEALY_STATES-1:0] state_q, state_d;
  logic                    legal;

  assign legal = (state_q != '0) && ((state_q & (state_q - 1'b1)) == '0);

  always_comb begin
    if (!legal) begin
      state_d = START;
    end else begin
      state_d       = '0;
      state_d[IX_A] = ~din & (state_q[IX_A] | state_q[IX_B] | state_q[IX_D]);
      state_d[IX_B] =  din & (state_q[IX_A] | state_q[IX_D]);
      state_d[IX_C] =  din & (state_q[IX_B] | state_q[IX_C]);
      state_d[IX_D] = ~din &  state_q[IX_C];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= START;
    else     state_q <= state_d;
  end

  assign hit = ~rst & din & legal & state_q[IX_D];

  // R8: an illegal one-hot value is cleared to the start state in one clock
  a_r8_mealy_recover: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_q) != 1) |=> state_q == START);
endmodule

// File: rtl/pd_moore_onehot.sv
module pd_moore_onehot
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  localparam logic [MOORE_STATES-1:0] START = MOORE_STATES'(1);

  logic [MOORE_STATES-1:0] state_q, state_d;
  logic                    legal;

  assign legal = (state_q != '0) && ((state_q & (state_q - 1'b1)) == '0);

  always_comb begin
    if (!legal) begin
      state_d = START;
    end else begin
      state_d       = '0;
      state_d[IX_A] = ~din & (state_q[IX_A] | state_q[IX_B] | state_q[IX_D] | state_q[IX_E]);
      state_d[IX_B] =  din &  state_q[IX_A];
      state_d[IX_C] =  din & (state_q[IX_B] | state_q[IX_C] | state_q[IX_E]);
      state_d[IX_D] = ~din &  state_q[IX_C];
      state_d[IX_E] =  din &  state_q[IX_D];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= START;
    else     state_q <= state_d;
  end

  assign hit = state_q[IX_E];

  // R1: an edge that sees reset leaves the start state
  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> state_q == START);

  // R8: illegal value recovers on the next edge
  a_r8_moore_recover: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_q) != 1) |=> state_q == START);
endmodule

// File: rtl/pd_pattern_watch.sv
module pd_pattern_watch
  import pd_pkg::*;
#(
  parameter mealy_enc_e MEALY_ENC = ENC_ONEHOT
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit_now,
  output logic hit_late
);
  if (MEALY_ENC == ENC_GRAY) begin : g_mealy_gray
    pd_mealy_gray u_mealy (
      .clk (clk),
      .rst (rst),
      .din (din),
      .hit (hit_now)
    );
  end else begin : g_mealy_oh
    pd_mealy_onehot u_mealy (
      .clk (clk),
      .rst (rst),
      .din (din),
      .hit (hit_now)
    );
  end

  pd_moore_onehot u_moore (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit_late)
  );

  // R5: the registered flag repeats the immediate flag one clock later
  a_r5_late_follows_now: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hit_late == $past(hit_now));
endmodule

// File: tb/test_pd_pattern_watch.sv
module test_pd_pattern_watch;
  import pd_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic now_oh, late_oh, now_gr, late_gr;

  always #10 clk = ~clk;

  pd_pattern_watch #(.MEALY_ENC(ENC_ONEHOT)) i_pd_pattern_watch (
    .clk(clk), .rst(rst), .din(din), .hit_now(now_oh), .hit_late(late_oh));

  pd_pattern_watch #(.MEALY_ENC(ENC_GRAY)) i_pd_pattern_watch_gray (
    .clk(clk), .rst(rst), .din(din), .hit_now(now_gr), .hit_late(late_gr));

  typedef struct {
    logic  exp_now;
    logic  exp_late;
    string tag;
  } item_t;

  item_t    sb[$];
  int       n_checks = 0;
  int       n_fail   = 0;
  logic [3:0] hist   = 4'b0000;
  logic     prev_hit = 1'b0;
  bit       done     = 1'b0;

  task automatic check(string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  // driver: one serial bit, reference is a four-bit shift of the input
  task automatic send(logic b, string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b0;
    din = b;
    hist = {hist[2:0], b};
    it.exp_now  = (hist == 4'b1101);
    it.exp_late = prev_hit;
    it.tag      = tag;
    prev_hit    = it.exp_now;
    sb.push_back(it);
  endtask

  task automatic send_str(string s, string tag);
    for (int i = 0; i < s.len(); i++) send(s[i] == "1", tag);
  endtask

  task automatic do_reset(int cycles, logic b);
    item_t it;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rst = 1'b1;
      din = b;
      it.exp_now  = 1'b0;
      it.exp_late = (i == 0) ? prev_hit : 1'b0;
      it.tag      = "R1";
      sb.push_back(it);
    end
    hist     = 4'b0000;
    prev_hit = 1'b0;
  endtask

  // monitor: mid-phase, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " hit_now onehot"},        now_oh,  it.exp_now);
        check({it.tag, " hit_late onehot (R5)"},  late_oh, it.exp_late);
        check({it.tag, " hit_now gray (R9)"},     now_gr,  it.exp_now);
        check({it.tag, " hit_late gray (R9)"},    late_gr, it.exp_late);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state with din held high
    do_reset(2, 1'b1);
    // R5/R6: sequence that walks every registered-machine transition
    send_str("0101110110011010", "R5");
    // R3: overlapping matches
    send_str("00", "R3");
    send_str("1101101", "R3");
    // R4: long run of ones
    send_str("00", "R4");
    send_str("1111101", "R4");
    // R6: ones after a completed match
    send_str("00", "R6");
    send_str("11011101", "R6");
    // R7: zero after 110 abandons the match
    send_str("00", "R7");
    send_str("11001", "R7");
    // R1: reset overrides a partial match
    send_str("110", "R1");
    do_reset(1, 1'b1);
    send_str("1", "R1");
    send_str("01101", "R1");
    // R8: illegal one-hot state recovers
    send_str("000", "R8");
    send(1'b0, "R8");
    force i_pd_pattern_watch.g_mealy_oh.u_mealy.state_q = 4'b0000;
    force i_pd_pattern_watch.u_moore.state_q = 5'b00000;
    #1;
    release i_pd_pattern_watch.g_mealy_oh.u_mealy.state_q;
    release i_pd_pattern_watch.u_moore.state_q;
    send_str("01101", "R8");
    // R2: pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      send(lfsr[0], "R2");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    send_str("0000", "R2");
    wait (sb.size() == 0);
    @(negedge clk);
    #8;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule